// File: doc/BRIEF.md
# Exception Vector and Cause Unit

This block is the exception-entry stage of a system-control coprocessor. Each cycle it takes a vector of fault requests, one bit per fault kind, together with one shared payload: the faulting virtual address, a store/load flag, an address-space identifier, a virtual page number and a coprocessor number. When any request bit is set it accepts exactly one fault by fixed priority. From the accepted kind it derives the 5-bit exception code and the handler address. On the next clock edge it loads the cause, bad-address, translation-entry-high and context fields, sets the exception-level bit and emits a one-cycle redirect strobe that carries the handler address.

The boot-vector select bit, the interrupt-vector select bit and the exception base register are inputs. The exception-level bit is held inside the unit. The return path clears it through a one-cycle clear input. Instruction decode, the translation lookup and the saved exception PC are handled elsewhere.

Top module: `exc_vector_unit`

## Requirements
- R1: While reset is asserted and after its release, with no request yet, every output is zero. This includes the redirect strobe and the exception-level bit.
- R2: Request bit index encodes the kind. From highest to lowest priority: 0 machine check, 1 address error, 2 TLB refill, 3 TLB invalid, 4 TLB modified, 5 system call, 6 breakpoint, 7 reserved instruction, 8 coprocessor unusable, 9 overflow, 10 trap, 11 thread, 12 interrupt. The lowest set bit is accepted.
- R3: The exception codes are: interrupt 0, TLB modified 1, system call 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24, thread 25.
- R4: An address error reports 5 for a store and 4 for a load. A TLB refill or TLB invalid fault reports 3 for a store and 2 for a load.
- R5: The handler address is base plus offset. The base is 0xBFC00200 when the boot-vector select bit is 1, and the exception base input when it is 0.
- R6: A TLB refill uses offset 0x180 if the exception-level bit was already set when the fault arrived, and 0x000 if it was clear.
- R7: An interrupt uses offset 0x200 when the interrupt-vector select bit is 1, and 0x000 when it is 0. Every other kind uses 0x180.
- R8: The bad-address output loads the fault address only for address errors and the three TLB kinds. Any other fault leaves it unchanged.
- R9: The three TLB kinds load the identifier into the entry-high ASID field, the page number shifted right by 2 into entry-high VPN2 and into context bad-VPN2, and the low two page-number bits into entry-high VPN2X. Other kinds leave these fields unchanged.
- R10: A coprocessor-unusable fault loads the coprocessor number into the cause CE field. Other kinds leave it unchanged.
- R11: The cycle after a request, the unit shows the accepted code in the cause code field, sets the exception-level bit, and raises the redirect strobe with the handler address for exactly that one cycle.
- R12: The exception-level clear input clears the bit on the next edge, unless a fault is accepted in the same cycle. In that case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_req | input | 13 | Fault request bits, one per kind |
| flt_vaddr | input | 32 | Faulting virtual address |
| flt_store | input | 1 | 1 = store access, 0 = load |
| flt_asid | input | 8 | Address-space identifier |
| flt_vpn | input | 21 | Faulting virtual page number |
| flt_cop | input | 2 | Coprocessor number for unusable faults |
| boot_vec_sel | input | 1 | 1 = fixed boot base, 0 = exception base |
| int_vec_sel | input | 1 | Interrupt special-offset select |
| exc_base | input | 32 | Exception base register value |
| exl_clear | input | 1 | Clears the exception-level bit |
| redirect_valid | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | 32 | Handler address |
| status_exl | output | 1 | Exception-level bit |
| cause_code | output | 5 | Cause exception code field |
| cause_ce | output | 2 | Cause coprocessor field |
| bad_vaddr | output | 32 | Bad virtual address register |
| ehi_asid | output | 8 | Entry-high ASID field |
| ehi_vpn2 | output | 19 | Entry-high VPN2 field |
| ehi_vpn2x | output | 2 | Entry-high VPN2X field |
| ctx_badvpn2 | output | 19 | Context bad-VPN2 field |

## Verification
Two things can land on the same edge. One is competing fault kinds, which the priority picker must resolve. The other is a fault together with the exception-level clear from the return path. The bench raises several request bits at once: machine check with address error and interrupt, address error with TLB refill, TLB invalid with interrupt, and trap with breakpoint. It judges each case by the code, the vector and which side registers moved. It also pulses the clear in the same cycle as a system call and expects the level bit to read 1 afterwards. A following refill must then take the 0x180 offset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int KIND_N = 13;
  localparam int KIND_W = $clog2(KIND_N);

  typedef enum logic [KIND_W-1:0] {
    K_MCHECK    = 4'd0,
    K_ADDR_ERR  = 4'd1,
    K_TLB_REFIL = 4'd2,
    K_TLB_INVAL = 4'd3,
    K_TLB_MOD   = 4'd4,
    K_SYSCALL   = 4'd5,
    K_BREAK     = 4'd6,
    K_RESV_INST = 4'd7,
    K_COP_UNUSE = 4'd8,
    K_OVERFLOW  = 4'd9,
    K_TRAP      = 4'd10,
    K_THREAD    = 4'd11,
    K_INTERRUPT = 4'd12
  } fault_kind_e;

  typedef enum logic [4:0] {
    C_INT    = 5'd0,
    C_MOD    = 5'd1,
    C_TLBL   = 5'd2,
    C_TLBS   = 5'd3,
    C_ADEL   = 5'd4,
    C_ADES   = 5'd5,
    C_SYS    = 5'd8,
    C_BP     = 5'd9,
    C_RI     = 5'd10,
    C_CPU    = 5'd11,
    C_OV     = 5'd12,
    C_TR     = 5'd13,
    C_MCHECK = 5'd24,
    C_THREAD = 5'd25
  } exc_code_e;

  localparam logic [31:0] BOOT_BASE   = 32'hBFC0_0200;
  localparam logic [31:0] OFS_GENERAL = 32'h0000_0180;
  localparam logic [31:0] OFS_INTVEC  = 32'h0000_0200;
  localparam logic [31:0] OFS_ZERO    = 32'h0000_0000;

  typedef struct packed {
    exc_code_e code;
    logic      wr_badv;
    logic      wr_tlb;
    logic      wr_ce;
  } fault_attr_t;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 13,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] grant;
  logic [N-1:0] seen;

  assign seen[0]  = 1'b0;
  assign grant[0] = req[0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign seen[i]  = seen[i-1] | req[i-1];
    assign grant[i] = req[i] & ~seen[i];
  end

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int j = 0; j < N; j++) begin
      if (grant[j]) idx = IW'(j);
    end
  end
endmodule

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_pkg::*;
(
  input  fault_kind_e kind,
  input  logic        store,
  input  logic        exl_now,
  input  logic        iv_sel,
  output fault_attr_t attr,
  output logic [31:0] offset
);
  always_comb begin
    attr.wr_badv = 1'b0;
    attr.wr_tlb  = 1'b0;
    attr.wr_ce   = 1'b0;
    offset       = OFS_GENERAL;
    unique case (kind)
      K_MCHECK:    attr.code = C_MCHECK;
      K_ADDR_ERR: begin
        attr.code    = store ? C_ADES : C_ADEL;
        attr.wr_badv = 1'b1;
      end
      K_TLB_REFIL: begin
        attr.code    = store ? C_TLBS : C_TLBL;
        attr.wr_badv = 1'b1;
        attr.wr_tlb  = 1'b1;
        offset       = exl_now ? OFS_GENERAL : OFS_ZERO;
      end
      K_TLB_INVAL: begin
        attr.code    = store ? C_TLBS : C_TLBL;
        attr.wr_badv = 1'b1;
        attr.wr_tlb  = 1'b1;
      end
      K_TLB_MOD: begin
        attr.code    = C_MOD;
        attr.wr_badv = 1'b1;
        attr.wr_tlb  = 1'b1;
      end
      K_SYSCALL:   attr.code = C_SYS;
      K_BREAK:     attr.code = C_BP;
      K_RESV_INST: attr.code = C_RI;
      K_COP_UNUSE: begin
        attr.code  = C_CPU;
        attr.wr_ce = 1'b1;
      end
      K_OVERFLOW:  attr.code = C_OV;
      K_TRAP:      attr.code = C_TR;
      K_THREAD:    attr.code = C_THREAD;
      K_INTERRUPT: begin
        attr.code = C_INT;
        offset    = iv_sel ? OFS_INTVEC : OFS_ZERO;
      end
      default:     attr.code = C_INT;
    endcase
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          boot_sel,
  input  logic [AW-1:0] ebase,
  input  logic [31:0]   offset,
  output logic [AW-1:0] vector
);
  logic [AW-1:0] base;
  assign base   = boot_sel ? AW'(BOOT_BASE) : ebase;
  assign vector = base + AW'(offset);
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 21,
  parameter int COP_W  = 2,
  localparam int V2_W  = VPN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KIND_N-1:0] flt_req,
  input  logic [AW-1:0]     flt_vaddr,
  input  logic              flt_store,
  input  logic [ASID_W-1:0] flt_asid,
  input  logic [VPN_W-1:0]  flt_vpn,
  input  logic [COP_W-1:0]  flt_cop,
  input  logic              boot_vec_sel,
  input  logic              int_vec_sel,
  input  logic [AW-1:0]     exc_base,
  input  logic              exl_clear,
  output logic              redirect_valid,
  output logic [AW-1:0]     redirect_pc,
  output logic              status_exl,
  output logic [4:0]        cause_code,
  output logic [COP_W-1:0]  cause_ce,
  output logic [AW-1:0]     bad_vaddr,
  output logic [ASID_W-1:0] ehi_asid,
  output logic [V2_W-1:0]   ehi_vpn2,
  output logic [1:0]        ehi_vpn2x,
  output logic [V2_W-1:0]   ctx_badvpn2
);
  logic              any_req;
  logic [KIND_W-1:0] sel_idx;
  fault_attr_t       attr;
  logic [31:0]       offset;
  logic [AW-1:0]     vector;

  exc_prio_sel #(.N(KIND_N)) u_prio (
    .req (flt_req),
    .any (any_req),
    .idx (sel_idx)
  );

  exc_code_map u_map (
    .kind    (fault_kind_e'(sel_idx)),
    .store   (flt_store),
    .exl_now (status_exl),
    .iv_sel  (int_vec_sel),
    .attr    (attr),
    .offset  (offset)
  );

  exc_vector_calc #(.AW(AW)) u_vec (
    .boot_sel (boot_vec_sel),
    .ebase    (exc_base),
    .offset   (offset),
    .vector   (vector)
  );

  // Clock enables
  logic en_badv, en_tlb, en_ce, en_exl;
  logic exl_nxt;

  always_comb begin
    en_badv = any_req & attr.wr_badv;
    en_tlb  = any_req & attr.wr_tlb;
    en_ce   = any_req & attr.wr_ce;
    en_exl  = any_req | exl_clear;
    exl_nxt = any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cause_code     <= '0;
    end else begin
      redirect_valid <= any_req;
      if (any_req) begin
        redirect_pc <= vector;
        cause_code  <= attr.code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_exl <= 1'b0;
    else if (en_exl) status_exl <= exl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bad_vaddr <= '0;
    else if (en_badv) bad_vaddr <= flt_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ehi_asid    <= '0;
      ehi_vpn2    <= '0;
      ehi_vpn2x   <= '0;
      ctx_badvpn2 <= '0;
    end else if (en_tlb) begin
      ehi_asid    <= flt_asid;
      ehi_vpn2    <= flt_vpn[VPN_W-1:2];
      ehi_vpn2x   <= flt_vpn[1:0];
      ctx_badvpn2 <= flt_vpn[VPN_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cause_ce <= '0;
    else if (en_ce) cause_ce <= flt_cop;
  end

  // Assertions
  p_pulse_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|flt_req) |-> (redirect_valid && status_exl));
  p_no_spurious_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(|flt_req));
  p_mcheck_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flt_req[0]) |-> (cause_code == 5'd24));
  p_boot_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|flt_req) && $past(boot_vec_sel)) |-> (redirect_pc[31:12] == 20'hBFC00));
  p_badv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flt_req == '0) |-> $stable(bad_vaddr));
  p_exl_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exl_clear && (flt_req == '0)) |-> !status_exl);
  p_ce_only_cop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause_ce) |-> (cause_code == 5'd11));
endmodule

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [12:0] flt_req;
  logic [31:0] flt_vaddr;
  logic        flt_store;
  logic [7:0]  flt_asid;
  logic [20:0] flt_vpn;
  logic [1:0]  flt_cop;
  logic        boot_vec_sel, int_vec_sel, exl_clear;
  logic [31:0] exc_base;
  logic        redirect_valid, status_exl;
  logic [31:0] redirect_pc, bad_vaddr;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce, ehi_vpn2x;
  logic [7:0]  ehi_asid;
  logic [18:0] ehi_vpn2, ctx_badvpn2;

  exc_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_vaddr(flt_vaddr),
    .flt_store(flt_store), .flt_asid(flt_asid), .flt_vpn(flt_vpn),
    .flt_cop(flt_cop), .boot_vec_sel(boot_vec_sel), .int_vec_sel(int_vec_sel),
    .exc_base(exc_base), .exl_clear(exl_clear),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .status_exl(status_exl), .cause_code(cause_code), .cause_ce(cause_ce),
    .bad_vaddr(bad_vaddr), .ehi_asid(ehi_asid), .ehi_vpn2(ehi_vpn2),
    .ehi_vpn2x(ehi_vpn2x), .ctx_badvpn2(ctx_badvpn2)
  );

  typedef struct {
    logic [31:0] pc;
    logic [4:0]  code;
    logic [1:0]  ce;
    logic [31:0] badv;
    logic [7:0]  asid;
    logic [18:0] vpn2;
    logic [1:0]  vpn2x;
    logic [18:0] ctx;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic        m_exl = 1'b0;
  logic [1:0]  m_ce = '0;
  logic [31:0] m_badv = '0;
  logic [7:0]  m_asid = '0;
  logic [18:0] m_vpn2 = '0, m_ctx = '0;
  logic [1:0]  m_vpn2x = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: model the expected result, push it, then apply the request.
  task automatic fire(input logic [12:0] req, input logic st, input logic [31:0] va,
                      input logic [7:0] asid, input logic [20:0] vpn,
                      input logic [1:0] cop, input logic bev, input logic iv,
                      input logic [31:0] eb, input logic clr, input string tag);
    exp_t e;
    int k = -1;
    logic [31:0] base, ofs;
    @(negedge clk);
    for (int i = 12; i >= 0; i--) if (req[i]) k = i;
    ofs = 32'h180;
    case (k)
      0: e.code = 5'd24;
      1: e.code = st ? 5'd5 : 5'd4;
      2: begin e.code = st ? 5'd3 : 5'd2; ofs = m_exl ? 32'h180 : 32'h0; end
      3: e.code = st ? 5'd3 : 5'd2;
      4: e.code = 5'd1;
      5: e.code = 5'd8;
      6: e.code = 5'd9;
      7: e.code = 5'd10;
      8: e.code = 5'd11;
      9: e.code = 5'd12;
      10: e.code = 5'd13;
      11: e.code = 5'd25;
      default: begin e.code = 5'd0; ofs = iv ? 32'h200 : 32'h0; end
    endcase
    base = bev ? 32'hBFC00200 : eb;
    e.pc = base + ofs;
    if (k >= 1 && k <= 4) m_badv = va;
    if (k >= 2 && k <= 4) begin
      m_asid = asid; m_vpn2 = vpn[20:2]; m_vpn2x = vpn[1:0]; m_ctx = vpn[20:2];
    end
    if (k == 8) m_ce = cop;
    m_exl = 1'b1;
    e.ce = m_ce; e.badv = m_badv; e.asid = m_asid; e.vpn2 = m_vpn2;
    e.vpn2x = m_vpn2x; e.ctx = m_ctx; e.tag = tag;
    q.push_back(e);
    flt_req = req; flt_store = st; flt_vaddr = va; flt_asid = asid;
    flt_vpn = vpn; flt_cop = cop; boot_vec_sel = bev; int_vec_sel = iv;
    exc_base = eb; exl_clear = clr;
    @(negedge clk);
    flt_req = '0; exl_clear = 1'b0;
  endtask

  // Monitor: pop and compare on every redirect.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && redirect_valid === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected redirect", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(redirect_pc === e.pc, e.tag, "pc", redirect_pc, e.pc);
        chk(cause_code === e.code, e.tag, "code", 32'(cause_code), 32'(e.code));
        chk(cause_ce === e.ce, e.tag, "ce", 32'(cause_ce), 32'(e.ce));
        chk(bad_vaddr === e.badv, e.tag, "badvaddr", bad_vaddr, e.badv);
        chk(ehi_asid === e.asid, e.tag, "asid", 32'(ehi_asid), 32'(e.asid));
        chk(ehi_vpn2 === e.vpn2, e.tag, "vpn2", 32'(ehi_vpn2), 32'(e.vpn2));
        chk(ehi_vpn2x === e.vpn2x, e.tag, "vpn2x", 32'(ehi_vpn2x), 32'(e.vpn2x));
        chk(ctx_badvpn2 === e.ctx, e.tag, "ctx", 32'(ctx_badvpn2), 32'(e.ctx));
        chk(status_exl === 1'b1, "R11", "exl set", 32'(status_exl), 32'd1);
      end
    end
  end

  task automatic clear_exl;
    @(negedge clk); exl_clear = 1'b1;
    @(negedge clk); exl_clear = 1'b0;
    m_exl = 1'b0;
    chk(status_exl === 1'b0, "R12", "exl after clear", 32'(status_exl), 32'd0);
  endtask

  initial begin
    #100000;
    chk(1'b0, "WATCHDOG", "timeout", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt_req = '0; flt_vaddr = '0; flt_store = 1'b0; flt_asid = '0;
    flt_vpn = '0; flt_cop = '0; boot_vec_sel = 1'b1; int_vec_sel = 1'b0;
    exc_base = 32'h8000_1000; exl_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({redirect_valid, status_exl, cause_code, cause_ce} === '0, "R1", "ctl", 32'(cause_code), 0);
    chk({redirect_pc, bad_vaddr, ehi_asid, ehi_vpn2, ehi_vpn2x, ctx_badvpn2} === '0,
        "R1", "regs", bad_vaddr, 0);

    // R3 R5 R7: syscall with boot base
    fire(13'h1 << 5, 0, 32'h1111_0000, 8'h00, 21'h0, 2'd0, 1, 0, 32'h8000_1000, 0, "R3_R5_syscall");
    clear_exl();
    // R6 R9 R4: refill load with EXL clear, ebase
    fire(13'h1 << 2, 0, 32'h1234_5678, 8'hA5, 21'h1ABCD, 2'd0, 0, 0, 32'h8000_1000, 0, "R6_R9_refill_exl0");
    // R6: refill store with EXL already set
    fire(13'h1 << 2, 1, 32'h2222_3333, 8'h3C, 21'h0F0F2, 2'd0, 0, 0, 32'h8000_1000, 0, "R6_R4_refill_exl1");
    // R4 R8: address errors
    fire(13'h1 << 1, 1, 32'hDEAD_BEEF, 8'h11, 21'h11111, 2'd0, 0, 0, 32'h8000_2000, 0, "R4_R8_ades");
    fire(13'h1 << 1, 0, 32'hCAFE_0004, 8'h11, 21'h11111, 2'd0, 1, 0, 32'h8000_2000, 0, "R4_adel");
    // R10 coprocessor unusable
    fire(13'h1 << 8, 0, 32'h5555_5555, 8'h22, 21'h02222, 2'd2, 0, 0, 32'h8000_3000, 0, "R10_cpu");
    // R8 R10: overflow leaves side registers
    fire(13'h1 << 9, 1, 32'h7777_7777, 8'h99, 21'h19999, 2'd1, 0, 0, 32'h8000_3000, 0, "R8_R10_ovf");
    // R7 interrupts
    fire(13'h1 << 12, 0, 32'h0, 8'h0, 21'h0, 2'd3, 0, 1, 32'h8000_4000, 0, "R7_int_iv1");
    fire(13'h1 << 12, 0, 32'h0, 8'h0, 21'h0, 2'd3, 1, 0, 32'h8000_4000, 0, "R7_int_iv0");
    // R3 remaining codes
    fire(13'h1 << 4, 1, 32'hAAAA_0000, 8'h44, 21'h00005, 2'd0, 0, 0, 32'h9000_0000, 0, "R3_R9_tlbmod");
    fire(13'h1 << 3, 1, 32'hBBBB_0000, 8'h45, 21'h00007, 2'd0, 0, 0, 32'h9000_0000, 0, "R4_tlbinval");
    fire(13'h1 << 11, 0, 32'h0, 8'h0, 21'h0, 2'd0, 0, 0, 32'h9000_0000, 0, "R3_thread");
    fire(13'h1 << 7, 0, 32'h0, 8'h0, 21'h0, 2'd0, 0, 0, 32'h9000_0000, 0, "R3_resv");
    fire(13'h1 << 10, 0, 32'h0, 8'h0, 21'h0, 2'd0, 0, 0, 32'h9000_0000, 0, "R3_trap");
    // R2 priority
    fire(13'h1003, 1, 32'h0101_0101, 8'h66, 21'h06666, 2'd0, 0, 1, 32'hA000_0000, 0, "R2_mcheck_first");
    fire(13'h0006, 1, 32'h0202_0202, 8'h67, 21'h06667, 2'd0, 0, 1, 32'hA000_0000, 0, "R2_addr_over_tlb");
    fire(13'h1008, 0, 32'h0303_0303, 8'h68, 21'h06668, 2'd0, 0, 1, 32'hA000_0000, 0, "R2_tlb_over_int");
    fire(13'h0440, 0, 32'h0, 8'h0, 21'h0, 2'd0, 0, 0, 32'hA000_0000, 0, "R2_break_over_trap");
    // R12: clear coinciding with a fault keeps EXL set, then refill takes 0x180
    clear_exl();
    fire(13'h1 << 5, 0, 32'h0, 8'h0, 21'h0, 2'd0, 0, 0, 32'hA000_0000, 1, "R12_clear_with_fault");
    fire(13'h1 << 2, 0, 32'h0404_0404, 8'h69, 21'h16669, 2'd0, 0, 0, 32'hA000_0000, 0, "R12_R6_refill_after");
    repeat (3) @(negedge clk);
    chk(redirect_valid === 1'b0, "R11", "strobe idle", 32'(redirect_valid), 0);
    chk(q.size() == 0, "R11", "pending items", 32'(q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule